// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block holds two configuration registers that are reached through an index/data pair sharing one write bus. Software first loads the index register with a register number, then reads the selected register or writes new contents to it. Access is open only while a configuration-mode input is high and the index names one of the two registers. The control register (number 00h) drives power, oscillator and a software-only valid flag. The pin register (number 01h) drives a pin-function select and holds the access enable.

The access enable is a one-way lock. Writing 0 to it closes the bank: every register read then returns 00h and every register write is dropped. Only a hard reset opens the bank again. A soft reset input restores the other fields and the index to their defaults but leaves the lock as it is. Read-only bits are stored nowhere. They are forced to fixed values on reads, and one of them always reads 1.

Top module: `cfg_reg_bank`

## Requirements
- R1: The index register loads `wdata` on a clock edge where `idx_we` and `cfg_mode` are both high. Register writes happen only while `cfg_mode` is high. A strobe that arrives while `cfg_mode` is low changes neither the index nor any register.
- R2: After a hard reset (`rst` high at a clock edge), register 00h reads 28h, register 01h reads 90h and the index is 00h. The outputs are then `fdc_pwr_o`=1, `osc_en_o`=1, `pdn_sel_o`=0 and `sw_valid_o`=0.
- R3: In register 00h, bits 0, 1, 2, 4 and 6 always read 0. Writes to these bits are ignored.
- R4: Register 00h bit 3 drives `fdc_pwr_o` (1 = powered). Bit 5 drives `osc_en_o` (1 = running). Bit 7 drives `sw_valid_o`, which has no other effect. All three bits are writable and read back their stored value.
- R5: In register 01h, bits 0, 1, 3, 5 and 6 always read 0 and bit 4 always reads 1, whatever is written.
- R6: Register 01h bit 2 drives `pdn_sel_o`. 0 selects normal drive-select/motor pins and 1 selects power-down/idle outputs. The bit is writable.
- R7: Register 01h bit 7 is the access enable. Writing 1 to it leaves it at 1, and writing 0 clears it. While it is 0, every read returns 00h and every register write is ignored. Only a hard reset sets it back to 1.
- R8: `rdata` is 00h while `cfg_mode` is low or the index is neither 00h nor 01h. A data write while the index is invalid changes no register.
- R9: A data write takes effect at the clock edge where `data_we` is sampled high. Outputs change only after that edge. `rdata` follows the index and the stored value combinationally.
- R10: A soft reset (`soft_rst` high at a clock edge) returns both registers to their power-up values and the index to 00h, except for the access enable, which keeps its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset, reopens the bank |
| soft_rst | input | 1 | Synchronous soft reset, keeps the access enable |
| cfg_mode | input | 1 | Configuration mode active |
| idx_we | input | 1 | Load index register from `wdata` |
| data_we | input | 1 | Write `wdata` into the indexed register |
| wdata | input | DATA_W | Shared write bus for index and data |
| rdata | output | DATA_W | Read value of the indexed register, 00h when closed |
| fdc_pwr_o | output | 1 | Disk controller power (1 = powered) |
| osc_en_o | output | 1 | Oscillator enable |
| pdn_sel_o | output | 1 | Pin-function select for power-down/idle |
| sw_valid_o | output | 1 | Software-owned valid flag |

## Verification
The checker assumes that `rst` is high during the first clock edges, so the reset-default property starts from known flops. It also assumes that soft and hard reset are the only ways to move the outputs while the bank is locked. The bench drives every input on the falling edge and keeps `rst` asserted for several cycles at the start. It raises `soft_rst` only as a one-cycle pulse between accesses, which keeps the stability property on locked outputs meaningful. Index values outside 00h–01h appear only in the directed tests for invalid access.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 8;
  localparam int NUM_REGS = 2;

  // register numbers
  localparam int REG_CTRL = 0;
  localparam int REG_PINS = 1;

  // bit positions inside the registers
  localparam int PWR_BIT   = 3;
  localparam int OSC_BIT   = 5;
  localparam int VALID_BIT = 7;
  localparam int PDN_BIT   = 2;
  localparam int LOCK_BIT  = 7;

  typedef logic [NUM_REGS-1:0][DATA_W-1:0] reg_table_t;

  // entry 0 = control register, entry 1 = pin register
  localparam reg_table_t REG_RST   = {8'h90, 8'h28};
  localparam reg_table_t REG_WR    = {8'h84, 8'hA8};
  localparam reg_table_t REG_ONES  = {8'h10, 8'h00};
  localparam reg_table_t REG_CLR   = {8'h80, 8'h00};
  localparam reg_table_t REG_KEEP  = {8'h80, 8'h00};
endpackage

// File: rtl/cfg_field_reg.sv
module cfg_field_reg #(
  parameter int             W         = 8,
  parameter logic [W-1:0]   RST_VAL   = '0,
  parameter logic [W-1:0]   WR_MASK   = '1,
  parameter logic [W-1:0]   ONES_MASK = '0,
  parameter logic [W-1:0]   CLR_MASK  = '0,
  parameter logic [W-1:0]   KEEP_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] rd_val
);
  localparam logic [W-1:0] STORE_RST = RST_VAL & WR_MASK;
  localparam logic [W-1:0] FREE_MASK = WR_MASK & ~CLR_MASK;

  logic [W-1:0] q_r;
  logic [W-1:0] wr_next;
  logic [W-1:0] soft_next;

  // plain bits take the bus, clear-only bits can only fall
  always_comb begin
    wr_next   = (wdata & FREE_MASK) | (wdata & q_r & CLR_MASK);
    soft_next = (STORE_RST & ~KEEP_MASK) | (q_r & KEEP_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= STORE_RST;
    end else if (soft_rst) begin
      q_r <= soft_next;
    end else if (we) begin
      q_r <= wr_next;
    end
  end

  assign q      = q_r;
  assign rd_val = (q_r & WR_MASK) | ONES_MASK;
endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      idx <= '0;
    end else if (load) begin
      idx <= din;
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux #(
  parameter int N     = 2,
  parameter int W     = 8,
  parameter int IDX_W = 8
) (
  input  logic [N-1:0][W-1:0] regs,
  input  logic [IDX_W-1:0]    idx,
  input  logic                open,
  output logic [W-1:0]        rdata
);
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

  logic             idx_ok;
  logic [SEL_W-1:0] sel;

  assign idx_ok = (idx < IDX_W'(N));
  assign sel    = idx[SEL_W-1:0];

  always_comb begin
    rdata = '0;
    if (open && idx_ok) begin
      rdata = regs[sel];
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_bank_pkg::*;
#(
  parameter int DATA_W = cfg_bank_pkg::DATA_W,
  parameter int IDX_W  = cfg_bank_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              cfg_mode,
  input  logic              idx_we,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              fdc_pwr_o,
  output logic              osc_en_o,
  output logic              pdn_sel_o,
  output logic              sw_valid_o
);
  localparam int N = NUM_REGS;

  logic [IDX_W-1:0]          idx_q;
  logic [N-1:0][DATA_W-1:0]  reg_q;
  logic [N-1:0][DATA_W-1:0]  reg_rd;
  logic [N-1:0]              reg_we;
  logic                      lock_q;
  logic                      access_open;

  cfg_index_reg #(.W(IDX_W)) u_index (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .load     (idx_we && cfg_mode),
    .din      (IDX_W'(wdata)),
    .idx      (idx_q)
  );

  for (genvar g = 0; g < N; g++) begin : g_reg
    assign reg_we[g] = data_we && access_open && (idx_q == IDX_W'(g));

    cfg_field_reg #(
      .W         (DATA_W),
      .RST_VAL   (DATA_W'(REG_RST[g])),
      .WR_MASK   (DATA_W'(REG_WR[g])),
      .ONES_MASK (DATA_W'(REG_ONES[g])),
      .CLR_MASK  (DATA_W'(REG_CLR[g])),
      .KEEP_MASK (DATA_W'(REG_KEEP[g]))
    ) u_reg (
      .clk      (clk),
      .rst      (rst),
      .soft_rst (soft_rst),
      .we       (reg_we[g]),
      .wdata    (wdata),
      .q        (reg_q[g]),
      .rd_val   (reg_rd[g])
    );
  end

  assign lock_q      = reg_q[REG_PINS][LOCK_BIT];
  assign access_open = cfg_mode && lock_q;

  cfg_read_mux #(.N(N), .W(DATA_W), .IDX_W(IDX_W)) u_rmux (
    .regs  (reg_rd),
    .idx   (idx_q),
    .open  (access_open),
    .rdata (rdata)
  );

  // outputs come straight from flops
  assign fdc_pwr_o  = reg_q[REG_CTRL][PWR_BIT];
  assign osc_en_o   = reg_q[REG_CTRL][OSC_BIT];
  assign sw_valid_o = reg_q[REG_CTRL][VALID_BIT];
  assign pdn_sel_o  = reg_q[REG_PINS][PDN_BIT];
endmodule

// File: rtl/cfg_reg_bank_chk.sv
module cfg_reg_bank_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic              cfg_mode,
  input logic [IDX_W-1:0]  idx_q,
  input logic              lock_q,
  input logic [DATA_W-1:0] rdata,
  input logic              fdc_pwr_o,
  input logic              osc_en_o,
  input logic              pdn_sel_o,
  input logic              sw_valid_o
);
  logic [3:0] outs;
  assign outs = {sw_valid_o, osc_en_o, fdc_pwr_o, pdn_sel_o};

  assert_reset_defaults_R2: assert property (@(posedge clk)
    rst |=> (fdc_pwr_o && osc_en_o && !pdn_sel_o && !sw_valid_o && lock_q && idx_q == '0));

  assert_ctrl_fixed_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && lock_q && idx_q == IDX_W'(0)) |-> ((rdata & DATA_W'(8'h57)) == '0));

  assert_ctrl_readback_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && lock_q && idx_q == IDX_W'(0)) |->
      (rdata[3] == fdc_pwr_o && rdata[5] == osc_en_o && rdata[7] == sw_valid_o));

  assert_pins_fixed_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && lock_q && idx_q == IDX_W'(1)) |->
      (rdata[4] && ((rdata & DATA_W'(8'h6B)) == '0)));

  assert_pins_readback_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && lock_q && idx_q == IDX_W'(1)) |-> (rdata[2] == pdn_sel_o && rdata[7]));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !lock_q |=> !lock_q);

  assert_locked_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !lock_q |-> (rdata == '0));

  assert_locked_outputs_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && !soft_rst) |=> $stable(outs));

  assert_closed_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode || idx_q > IDX_W'(1)) |-> (rdata == '0));

  assert_soft_reset_index_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (idx_q == '0));
endmodule

bind cfg_reg_bank cfg_reg_bank_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .soft_rst   (soft_rst),
  .cfg_mode   (cfg_mode),
  .idx_q      (idx_q),
  .lock_q     (lock_q),
  .rdata      (rdata),
  .fdc_pwr_o  (fdc_pwr_o),
  .osc_en_o   (osc_en_o),
  .pdn_sel_o  (pdn_sel_o),
  .sw_valid_o (sw_valid_o)
);

// File: tb/cfg_reg_bank_tb_top.sv
module cfg_reg_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, soft_rst, cfg_mode, idx_we, data_we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       fdc_pwr_o, osc_en_o, pdn_sel_o, sw_valid_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_reg_bank dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_mode(cfg_mode),
    .idx_we(idx_we), .data_we(data_we), .wdata(wdata), .rdata(rdata),
    .fdc_pwr_o(fdc_pwr_o), .osc_en_o(osc_en_o),
    .pdn_sel_o(pdn_sel_o), .sw_valid_o(sw_valid_o)
  );

  // outs = {sw_valid_o, osc_en_o, fdc_pwr_o, pdn_sel_o}
  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] din;
    logic [7:0] rd;
    logic [3:0] outs;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'hFF, 8'hA8, 4'b1110},
    '{8'h00, 8'h00, 8'h00, 4'b0000},
    '{8'h00, 8'h57, 8'h00, 4'b0000},
    '{8'h00, 8'h08, 8'h08, 4'b0010},
    '{8'h00, 8'h20, 8'h20, 4'b0100},
    '{8'h01, 8'hFF, 8'h94, 4'b0101},
    '{8'h01, 8'hEB, 8'h90, 4'b0100},
    '{8'h01, 8'h84, 8'h94, 4'b0101},
    '{8'h00, 8'h88, 8'h88, 4'b1011}
  };

  function automatic logic [3:0] outs_now();
    return {sw_valid_o, osc_en_o, fdc_pwr_o, pdn_sel_o};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_idx(input logic [7:0] v);
    idx_we = 1'b1; wdata = v;
    tick();
    idx_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    data_we = 1'b1; wdata = v;
    tick();
    data_we = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; soft_rst = 1'b0; cfg_mode = 1'b1;
    idx_we = 1'b0; data_we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: defaults after hard reset, index starts at 00h
    check("R2 reg00 default", rdata, 8'h28);
    check("R2 outputs default", {4'b0, outs_now()}, 8'b0110);
    wr_idx(8'h01);
    check("R2 reg01 default", rdata, 8'h90);

    // table walk: R3 R4 R5 R6 read-only masking and output mapping
    for (int i = 0; i < NVEC; i++) begin
      wr_idx(VECS[i].idx);
      wr_dat(VECS[i].din);
      check($sformatf("R3 R4 R5 R6 vector %0d readback", i), rdata, VECS[i].rd);
      check($sformatf("R4 R6 vector %0d outputs", i), {4'b0, outs_now()}, {4'b0, VECS[i].outs});
    end
    // now reg00 = 88h, reg01 = 94h, index = 00h

    // R8 and R1: configuration mode off
    cfg_mode = 1'b0;
    #1 check("R8 read with cfg_mode low", rdata, 8'h00);
    wr_dat(8'h00);
    check("R1 data write ignored outside cfg mode", {4'b0, outs_now()}, 8'b1011);
    wr_idx(8'h01);
    cfg_mode = 1'b1;
    #1 check("R1 index write ignored outside cfg mode", rdata, 8'h88);

    // R8: invalid index
    @(negedge clk);
    wr_idx(8'h05);
    check("R8 read with invalid index", rdata, 8'h00);
    wr_dat(8'hFF);
    wr_idx(8'h00);
    check("R8 reg00 untouched by invalid index", rdata, 8'h88);
    wr_idx(8'h01);
    check("R8 reg01 untouched by invalid index", rdata, 8'h94);
    check("R8 outputs untouched", {4'b0, outs_now()}, 8'b1011);

    // R9: change happens at the sampling edge
    wr_idx(8'h00);
    data_we = 1'b1; wdata = 8'h00;
    #1 check("R9 outputs before edge", {4'b0, outs_now()}, 8'b1011);
    check("R9 read before edge", rdata, 8'h88);
    @(posedge clk);
    #1 check("R9 outputs after edge", {4'b0, outs_now()}, 8'b0001);
    check("R9 read follows store", rdata, 8'h00);
    @(negedge clk);
    data_we = 1'b0;

    // R10: soft reset restores defaults and index
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    check("R10 soft reset reg00 and index", rdata, 8'h28);
    check("R10 soft reset outputs", {4'b0, outs_now()}, 8'b0110);
    wr_idx(8'h01);
    check("R10 soft reset reg01", rdata, 8'h90);

    // R7: lock the bank
    wr_dat(8'h04);
    check("R7 locked read returns zero", rdata, 8'h00);
    check("R7 last write before lock applied", {4'b0, outs_now()}, 8'b0111);
    wr_idx(8'h00);
    wr_dat(8'hFF);
    check("R7 write ignored when locked", {4'b0, outs_now()}, 8'b0111);
    check("R7 reg00 read blocked", rdata, 8'h00);
    wr_idx(8'h01);
    wr_dat(8'h80);
    check("R7 lock cannot be reopened by write", rdata, 8'h00);

    // R10: soft reset while locked keeps the lock
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    check("R10 soft reset outputs while locked", {4'b0, outs_now()}, 8'b0110);
    check("R10 lock kept over soft reset", rdata, 8'h00);

    // R7: hard reset reopens
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R7 hard reset reopens reg00", rdata, 8'h28);
    wr_idx(8'h01);
    check("R7 hard reset reopens reg01", rdata, 8'h90);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule